// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between a synchronous host and an external asynchronous static RAM of 16K words by 4 bits. The RAM has active-low chip select, write enable and output enable strobes and one shared bidirectional data bus. The host raises a request with a direction bit, a 14-bit word address and write data. It holds them until the block answers with a single-cycle ready pulse. For a read, the word fetched from the RAM comes back on the same pulse.

Every timing interval is a parameter counted in system clock cycles: read access, nominal write pulse, data setup before the end of a write, the time the RAM needs to release the bus once output enable goes high, and the recovery gap after each access. An access runs as follows. The address is loaded while every strobe is high. The strobes then open for the counted interval. Read data is sampled as the access count expires, and a recovery gap follows. The data pad is split into an output word, an output-enable and an input word, which the pad ring joins into the tri-state bus.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is active and after its release with no request: ram_cs_n, ram_we_n and ram_oe_n are 1, ram_dq_oe is 0, host_ready is 0 and host_rdata is 0.
- R2: A read holds ram_cs_n=0, ram_oe_n=0 and ram_we_n=1 for exactly RD_CYC cycles. ram_dq_in is sampled at the clock edge that ends the last of them. host_ready=1 then comes with that word on host_rdata. ram_oe_n is low only during such a read.
- R3: A write holds ram_cs_n=0 and ram_we_n=0 together for exactly max(WP_CYC, TURN_CYC+DSU_CYC) cycles. ram_oe_n stays 1 throughout, and the word written is the host write data.
- R4: During a write, ram_dq_oe stays 0 for the first TURN_CYC cycles. It is then 1, with ram_dq_out unchanged, up to and including the last cycle of the write, which is at least DSU_CYC cycles. It is 0 again once the strobes rise.
- R5: ram_dq_oe is never 1 while ram_oe_n is 0, so the block and the RAM never drive the bus together.
- R6: ram_addr is unchanged during every cycle in which ram_cs_n is 0. It changes only while all strobes are high.
- R7: After each access, ram_cs_n stays high for at least REC_CYC cycles. With the next request already waiting, the gap is exactly REC_CYC+2 cycles (recovery, acceptance, address load).
- R8: Request fields are captured when the request is accepted. Changes to host_addr, host_wdata or host_wr after acceptance have no effect on the access in progress.
- R9: host_ready is 1 for exactly one cycle per accepted request and is never 1 without one.
- R10: ram_we_n is low only while ram_cs_n is low. Both fall and rise on the same edge, so a write takes place only within their overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_req | input | 1 | Request pending; held until host_ready |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 14 | Word address |
| host_wdata | input | 4 | Write data |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 4 | Read word, valid with host_ready after a read |
| ram_addr | output | 14 | RAM address lines |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_dq_out | output | 4 | Word driven onto the data bus |
| ram_dq_oe | output | 1 | Enable of the block's data bus driver |
| ram_dq_in | input | 4 | Word read from the data bus |

## Verification
The RAM model returns inverted data until its output has been selected for RD_CYC-1 counted cycles. A design that samples even one cycle early therefore returns a wrong word. The model commits a write only at the end of the select and write-enable overlap, using the last word driven. It flags bus contention, any address change under an open select, and output enable going low during a write. A driver enabled too early or released too late, a truncated write pulse, a sequencer that re-reads request fields after acceptance, or a recovery gap cut short each show up as a wrong stored word, a wrong pulse length or a wrong gap count.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_READ,
    ST_WRITE,
    ST_RECOV
  } sramc_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign expired = (cnt_q == '0);
  assign cnt_en  = load | ~expired;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
  import sramc_pkg::*;
#(
  parameter int CNT_W   = 3,
  parameter int RD_CYC  = 4,
  parameter int WR_CYC  = 5,
  parameter int REC_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             op_wr,
  input  logic             expired,
  output sramc_state_e     state,
  output logic             accept,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             rd_done,
  output logic             wr_done
);

  localparam logic [CNT_W-1:0] LD_RD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_WR  = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] LD_REC = CNT_W'(REC_CYC - 1);

  sramc_state_e st_q;
  sramc_state_e st_d;

  always_comb begin
    st_d     = st_q;
    accept   = 1'b0;
    load     = 1'b0;
    load_val = '0;
    rd_done  = 1'b0;
    wr_done  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req) begin
          accept = 1'b1;
          st_d   = ST_ADDR;
        end
      end
      ST_ADDR: begin
        load = 1'b1;
        if (op_wr) begin
          load_val = LD_WR;
          st_d     = ST_WRITE;
        end else begin
          load_val = LD_RD;
          st_d     = ST_READ;
        end
      end
      ST_READ: begin
        if (expired) begin
          rd_done  = 1'b1;
          load     = 1'b1;
          load_val = LD_REC;
          st_d     = ST_RECOV;
        end
      end
      ST_WRITE: begin
        if (expired) begin
          wr_done  = 1'b1;
          load     = 1'b1;
          load_val = LD_REC;
          st_d     = ST_RECOV;
        end
      end
      ST_RECOV: begin
        if (expired) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;

endmodule

// File: rtl/sramc_dpath.sv
module sramc_dpath #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              rd_done,
  input  logic              wr_done,
  input  logic [DATA_W-1:0] dq_in,
  output logic              op_wr,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ready
);

  logic              op_wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_wr_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      op_wr_q <= req_wr;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_done) rdata_q <= dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= rd_done | wr_done;
  end

  assign op_wr = op_wr_q;
  assign addr  = addr_q;
  assign wdata = wdata_q;
  assign rdata = rdata_q;
  assign ready = ready_q;

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sramc_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int DATA_W   = 4,
  parameter int RD_CYC   = 4,
  parameter int WP_CYC   = 3,
  parameter int TURN_CYC = 2,
  parameter int DSU_CYC  = 3,
  parameter int REC_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_cs_n,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_in
);

  localparam int WR_CYC  = max2(WP_CYC, TURN_CYC + DSU_CYC);
  localparam int MAX_CYC = max2(max2(RD_CYC, WR_CYC), REC_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] DRV_LIM = CNT_W'(WR_CYC - TURN_CYC);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  sramc_state_e     state;
  logic             accept;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt;
  logic             expired;
  logic             rd_done;
  logic             wr_done;
  logic             op_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sramc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (load),
    .load_val (load_val),
    .cnt      (cnt),
    .expired  (expired)
  );

  sramc_seq #(
    .CNT_W   (CNT_W),
    .RD_CYC  (RD_CYC),
    .WR_CYC  (WR_CYC),
    .REC_CYC (REC_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .req      (host_req),
    .op_wr    (op_wr),
    .expired  (expired),
    .state    (state),
    .accept   (accept),
    .load     (load),
    .load_val (load_val),
    .rd_done  (rd_done),
    .wr_done  (wr_done)
  );

  sramc_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .accept    (accept),
    .req_wr    (host_wr),
    .req_addr  (host_addr),
    .req_wdata (host_wdata),
    .rd_done   (rd_done),
    .wr_done   (wr_done),
    .dq_in     (ram_dq_in),
    .op_wr     (op_wr),
    .addr      (ram_addr),
    .wdata     (ram_dq_out),
    .rdata     (host_rdata),
    .ready     (host_ready)
  );

  // Strobes decode straight from registered state; select and write enable
  // share one state so they open and close on the same edge.
  assign ram_cs_n  = ~((state == ST_READ) | (state == ST_WRITE));
  assign ram_we_n  = ~(state == ST_WRITE);
  assign ram_oe_n  = ~(state == ST_READ);
  assign ram_dq_oe = (state == ST_WRITE) && (cnt < DRV_LIM);

endmodule

// File: rtl/sramc_chk.sv
module sramc_chk #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              dq_oe,
  input logic [DATA_W-1:0] dq_out,
  input logic [ADDR_W-1:0] addr,
  input logic              ready
);

  AST_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !cs_n); // R10

  AST_STROBES_CLOSE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> $rose(cs_n)); // R10

  AST_OE_ONLY_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (we_n && !cs_n)); // R2

  AST_NO_BUS_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n); // R5

  AST_DRIVE_ONLY_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !we_n); // R4

  AST_DRIVE_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |-> $stable(dq_out)); // R4

  AST_ADDR_HELD_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> $stable(addr)); // R6

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready); // R9

endmodule

bind sram_async_ctrl sramc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sramc_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cs_n   (ram_cs_n),
  .we_n   (ram_we_n),
  .oe_n   (ram_oe_n),
  .dq_oe  (ram_dq_oe),
  .dq_out (ram_dq_out),
  .addr   (ram_addr),
  .ready  (host_ready)
);

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;

  localparam int RD   = 4;
  localparam int WP   = 3;
  localparam int TURN = 2;
  localparam int DSU  = 3;
  localparam int REC  = 2;
  localparam int WRC  = (WP > TURN + DSU) ? WP : TURN + DSU;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_req;
  logic        host_wr;
  logic [13:0] host_addr;
  logic [3:0]  host_wdata;
  logic        host_ready;
  logic [3:0]  host_rdata;
  logic [13:0] ram_addr;
  logic        ram_cs_n, ram_we_n, ram_oe_n;
  logic [3:0]  ram_dq_out;
  logic        ram_dq_oe;
  logic [3:0]  ram_dq_in;

  always #2.5 clk = ~clk;

  sram_async_ctrl #(
    .RD_CYC(RD), .WP_CYC(WP), .TURN_CYC(TURN), .DSU_CYC(DSU), .REC_CYC(REC)
  ) i_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_ready(host_ready), .host_rdata(host_rdata),
    .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n),
    .ram_oe_n(ram_oe_n), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe),
    .ram_dq_in(ram_dq_in)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // ---------------- RAM model ----------------
  logic [3:0] mem_m [int];
  logic [3:0] ref_m [int];
  logic [3:0] rd_word = 4'h0;
  int         sel_cnt = 0;

  function automatic logic [3:0] mem_look(input int a);
    if (mem_m.exists(a)) return mem_m[a];
    return 4'h0;
  endfunction

  function automatic logic [3:0] ref_look(input int a);
    if (ref_m.exists(a)) return ref_m[a];
    return 4'h0;
  endfunction

  assign ram_dq_in = (!ram_cs_n && ram_we_n && !ram_oe_n) ?
                     ((sel_cnt >= RD - 1) ? rd_word : ~rd_word) : 4'h0;

  always @(posedge clk) begin
    rd_word <= mem_look(int'(ram_addr));
    if (!ram_cs_n && ram_we_n && !ram_oe_n) sel_cnt <= sel_cnt + 1;
    else                                    sel_cnt <= 0;
  end

  // ---------------- bus monitor (values of the cycle just ended) ----------
  int         contention = 0, addr_bad = 0, oe_bad = 0, rel_bad = 0;
  bit         wr_act = 0;
  int         wr_len = 0, drv_run = 0, last_wlen = 0, last_drv = 0;
  logic [3:0] last_d = 4'h0;
  logic [13:0] wr_addr = '0, prev_addr = '0;
  int         lo_run = 0, hi_run = 0, last_lo = 0, last_gap = 0;
  bit         last_cs_n = 1;

  always @(posedge clk) begin
    if (ram_dq_oe && !ram_oe_n) contention++;
    if (!ram_cs_n && !ram_we_n) begin
      if (!wr_act) begin
        wr_act = 1; wr_len = 0; drv_run = 0; wr_addr = ram_addr;
      end
      wr_len++;
      if (!ram_oe_n) oe_bad++;
      if (ram_dq_oe) begin drv_run++; last_d = ram_dq_out; end
      else drv_run = 0;
    end else if (wr_act) begin
      wr_act = 0;
      mem_m[int'(wr_addr)] = last_d;
      last_wlen = wr_len;
      last_drv  = drv_run;
      if (ram_dq_oe) rel_bad++;
    end
    if (!ram_cs_n) begin
      if (last_cs_n) begin last_gap = hi_run; lo_run = 0; end
      else if (ram_addr != prev_addr) addr_bad++;
      lo_run++;
    end else begin
      if (!last_cs_n) begin last_lo = lo_run; hi_run = 0; end
      hi_run++;
    end
    prev_addr = ram_addr;
    last_cs_n = ram_cs_n;
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      bad++;
      total++;
      $display("FAIL watchdog R9: actual=%0d expected=%0d", cyc, 50000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- host tasks ----------------
  task automatic access(input bit wr, input logic [13:0] a, input logic [3:0] d,
                        input bit drop, output logic [3:0] rd);
    int n = 0;
    host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
    do begin @(negedge clk); n++; end while (!host_ready && n < 200);
    chk(host_ready, "R9", "ready after request", n, 200);
    rd = host_rdata;
    if (wr) ref_m[int'(a)] = d;
    if (drop) begin
      host_req = 1'b0;
      @(negedge clk);
      chk(!host_ready, "R9", "ready lasts one cycle", int'(host_ready), 0);
      if (wr) begin
        chk(last_wlen == WRC, "R3", "write overlap length", last_wlen, WRC);
        chk(last_drv >= DSU && last_drv <= WRC - TURN, "R4",
            "driver cycles before write end", last_drv, WRC - TURN);
      end else begin
        chk(last_lo == RD, "R2", "read select length", last_lo, RD);
      end
    end
  endtask

  task automatic read_expect(input logic [13:0] a, input string rq);
    logic [3:0] v;
    access(1'b0, a, 4'h0, 1'b1, v);
    chk(v == ref_look(int'(a)), rq, "read data", int'(v), int'(ref_look(int'(a))));
  endtask

  task automatic write_word(input logic [13:0] a, input logic [3:0] d);
    logic [3:0] v;
    access(1'b1, a, d, 1'b1, v);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; host_req = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
    repeat (4) @(negedge clk);
    chk(ram_cs_n && ram_we_n && ram_oe_n, "R1", "strobes high in reset",
        int'({ram_cs_n, ram_we_n, ram_oe_n}), 7);
    chk(!ram_dq_oe && !host_ready && host_rdata == 4'h0, "R1", "driver/ready/rdata in reset",
        int'({ram_dq_oe, host_ready, host_rdata}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ram_cs_n && ram_we_n && ram_oe_n && !ram_dq_oe && !host_ready, "R1",
        "idle after release", int'({ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe, host_ready}), 28);
  endtask

  task automatic t_write_read;
    write_word(14'h0000, 4'h5);
    write_word(14'h3FFF, 4'hA);
    write_word(14'h1234, 4'hF);
    write_word(14'h2AAA, 4'h0);
    read_expect(14'h0000, "R2");
    read_expect(14'h3FFF, "R2");
    read_expect(14'h1234, "R3");
    read_expect(14'h2AAA, "R3");
    for (int i = 0; i < 4; i++) write_word(14'(14'h0100 + i), 4'(1 << i));
    for (int i = 0; i < 4; i++) read_expect(14'(14'h0100 + i), "R4");
    write_word(14'h1234, 4'h6);
    read_expect(14'h1234, "R3");
  endtask

  task automatic t_capture;
    int n = 0;
    host_req = 1'b1; host_wr = 1'b1; host_addr = 14'h0777; host_wdata = 4'hC;
    do begin @(negedge clk); n++; end while (ram_cs_n && n < 100);
    host_addr = 14'h1234; host_wdata = 4'h3; host_wr = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!host_ready && n < 100);
    chk(host_ready, "R8", "ready for captured write", n, 100);
    host_req = 1'b0;
    ref_m[int'(14'h0777)] = 4'hC;
    @(negedge clk);
    read_expect(14'h0777, "R8");
    read_expect(14'h1234, "R8");
  endtask

  task automatic t_back_to_back;
    logic [3:0] v;
    access(1'b0, 14'h0000, 4'h0, 1'b0, v);
    chk(v == ref_look(0), "R7", "first chained read", int'(v), int'(ref_look(0)));
    access(1'b0, 14'h3FFF, 4'h0, 1'b1, v);
    chk(v == ref_look(int'(14'h3FFF)), "R7", "second chained read", int'(v),
        int'(ref_look(int'(14'h3FFF))));
    chk(last_gap == REC + 2, "R7", "select gap between chained reads", last_gap, REC + 2);
    access(1'b1, 14'h0200, 4'h9, 1'b0, v);
    access(1'b1, 14'h0201, 4'h7, 1'b1, v);
    chk(last_gap == REC + 2, "R7", "select gap between chained writes", last_gap, REC + 2);
    read_expect(14'h0200, "R7");
    read_expect(14'h0201, "R7");
  endtask

  task automatic t_idle;
    int rdy = 0, sel = 0;
    host_req = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (host_ready) rdy++;
      if (!ram_cs_n) sel++;
    end
    chk(rdy == 0, "R9", "no ready without request", rdy, 0);
    chk(sel == 0, "R10", "no select without request", sel, 0);
  endtask

  initial begin
    t_reset();
    t_write_read();
    t_capture();
    t_back_to_back();
    t_idle();
    chk(contention == 0, "R5", "cycles with both drivers on", contention, 0);
    chk(addr_bad == 0, "R6", "address changes under select", addr_bad, 0);
    chk(oe_bad == 0, "R3", "output enable low during write", oe_bad, 0);
    chk(rel_bad == 0, "R4", "driver left on after write", rel_bad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule